// File: doc/BRIEF.md
# DRAM Initialization Control Register

This block is the control and status register a DDR memory controller exposes for memory bring-up. After reset the controller sits in initialization mode. Data traffic and automatic refresh toward the memory are held off, and software drives the memory's clock-enable pin directly. Software launches single initialization commands to a command sequencer. Each command is configured elsewhere and is started by writing 1 to a command bit. A ready flag tells software when the next command may be written. When initialization completes, the controller core pulses `init_done` and the block returns to normal operation on its own. In normal operation clock-enable is held high and traffic is released.

The register is 16 bits wide and sits on a simple single-cycle write port with a combinational read value. Two state machines hold the state.

The mode machine has the states `MODE_INIT` and `MODE_RUN`. Its transitions are:
- INIT_TO_RUN: taken on `init_done`, or on a software write with the mode bit at 0.
- RUN_TO_INIT: taken on a software write with the mode bit at 1, provided `access_busy` is 0 and `init_done` is 0.

The command machine has the states `CMD_READY`, `CMD_ISSUE` and `CMD_WAIT`. Its transitions are:
- ACCEPT (READY to ISSUE): taken on an accepted command write.
- ISSUE_TO_WAIT: taken when no done pulse arrives during ISSUE.
- ISSUE_TO_READY: taken when the done pulse arrives during ISSUE.
- WAIT_TO_READY: taken on `cmd_done`.

Top module: `dram_init_ctrl`

## Requirements
- R1: After reset the mode bit (bit 15) is 1, the stored clock-enable bit (bit 14) is 0, `cke` is 0, `cmd_issue` is 0 and command-ready (bit 1) is 1. With idle status inputs, `rd_data` reads 0x8002.
- R2: A cycle with `init_done` high clears the mode bit on the next edge. This takes priority over a software write of 1 to bit 15 in the same cycle.
- R3: A write with bit 15 at 0 leaves initialization mode. A write with bit 15 at 1 while in normal operation enters initialization mode only when `access_busy` is 0 in that cycle; otherwise the mode stays 0.
- R4: In normal operation `cke` is 1. In initialization mode `cke` equals the stored bit 14.
- R5: A write to bit 14 is stored only when the mode bit is 1 before that write. In normal operation it is ignored, which shows in bit 14 of `rd_data` and in `cke` once initialization mode is entered again.
- R6: Reserved bits 13 to 4 and the write-only bit 0 always read 0, whatever was written to them.
- R7: Bit 3 reads the `refresh_active` input and bit 2 reads the `access_busy` input in the same cycle.
- R8: Command-ready (bit 1) reads 1 only while the mode bit is 1 and no command is outstanding.
- R9: A write with bit 0 at 1 while command-ready is 1 is accepted. `cmd_issue` is then high for exactly the one cycle after the write. Command-ready reads 0 from that cycle until the edge after `cmd_done` is seen.
- R10: A write with bit 0 at 1 while command-ready is 0, including any such write in normal operation, produces no `cmd_issue` pulse.
- R11: `hold_traffic` equals the mode bit at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 16 | Register write data |
| rd_data | output | 16 | Register read value |
| refresh_active | input | 1 | Refresh cycle in progress, from the refresh engine |
| access_busy | input | 1 | Command request or data access outstanding |
| init_done | input | 1 | Initialization completed, one-cycle pulse |
| cmd_done | input | 1 | Sequencer finished the issued command, one-cycle pulse |
| cmd_issue | output | 1 | One-cycle launch pulse to the sequencer |
| cke | output | 1 | Memory clock-enable |
| hold_traffic | output | 1 | Suppress data accesses and automatic refresh |

## Verification
The sharpest overlap is between the hardware completion clear and the software mode write. The bench drives a write of 1 to bit 15 in the very cycle `init_done` pulses, and expects the mode bit to read 0 afterwards. A second overlap combines leaving initialization mode with launching a command in one write of 0x4001. That write must both issue the command and store bit 14, because both decisions use the mode bit as it stood before the write. The bench judges this by the `cmd_issue` pulse and by `rd_data` reading 0x4000 afterwards. A done pulse arriving during the issue cycle itself is also driven, to confirm that command-ready returns without passing through the wait state.

// File: rtl/dinit_pkg.sv
package dinit_pkg;
    localparam int REG_W  = 16;
    localparam int B_MODE = 15;
    localparam int B_CKE  = 14;
    localparam int B_RSV_HI = 13;
    localparam int B_RSV_LO = 4;
    localparam int B_REFR = 3;
    localparam int B_BUSY = 2;
    localparam int B_RDY  = 1;
    localparam int B_CMD  = 0;

    typedef enum logic [0:0] {
        MODE_INIT = 1'b0,
        MODE_RUN  = 1'b1
    } mode_state_e;

    typedef enum logic [1:0] {
        CMD_READY = 2'd0,
        CMD_ISSUE = 2'd1,
        CMD_WAIT  = 2'd2
    } cmd_state_e;
endpackage

// File: rtl/dinit_mode_fsm.sv
module dinit_mode_fsm
    import dinit_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wr_en,
    input  logic wr_mode,
    input  logic wr_cke,
    input  logic access_busy,
    input  logic init_done,
    output logic init_mode,
    output logic cke_ctl
);
    mode_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= MODE_INIT;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            MODE_INIT: begin
                if (init_done)               state_d = MODE_RUN;
                else if (wr_en && !wr_mode)  state_d = MODE_RUN;
            end
            MODE_RUN: begin
                if (wr_en && wr_mode && !access_busy && !init_done)
                    state_d = MODE_INIT;
            end
            default: state_d = MODE_INIT;
        endcase
    end

    // Clock-enable control is only writable while initialization mode holds.
    always_ff @(posedge clk) begin
        if (!rst_n)                                cke_ctl <= 1'b0;
        else if (wr_en && state_q == MODE_INIT)    cke_ctl <= wr_cke;
    end

    always_comb begin
        init_mode = (state_q == MODE_INIT);
    end
endmodule

// File: rtl/dinit_cmd_fsm.sv
module dinit_cmd_fsm
    import dinit_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wr_en,
    input  logic wr_cmd,
    input  logic init_mode,
    input  logic cmd_done,
    output logic cmd_issue,
    output logic cmd_ready
);
    cmd_state_e state_q, state_d;
    logic       accept;

    assign accept = wr_en && wr_cmd && init_mode && (state_q == CMD_READY);

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= CMD_READY;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CMD_READY: if (accept)   state_d = CMD_ISSUE;
            CMD_ISSUE: state_d = cmd_done ? CMD_READY : CMD_WAIT;
            CMD_WAIT:  if (cmd_done) state_d = CMD_READY;
            default:   state_d = CMD_READY;
        endcase
    end

    always_comb begin
        cmd_issue = (state_q == CMD_ISSUE);
        cmd_ready = (state_q == CMD_READY) && init_mode;
    end
endmodule

// File: rtl/dinit_readback.sv
module dinit_readback
    import dinit_pkg::*;
#(
    parameter int W = REG_W
) (
    input  logic         init_mode,
    input  logic         cke_ctl,
    input  logic         refresh_active,
    input  logic         access_busy,
    input  logic         cmd_ready,
    output logic [W-1:0] rd_data
);
    always_comb begin
        rd_data         = '0;
        rd_data[B_MODE] = init_mode;
        rd_data[B_CKE]  = cke_ctl;
        rd_data[B_REFR] = refresh_active;
        rd_data[B_BUSY] = access_busy;
        rd_data[B_RDY]  = cmd_ready;
    end
endmodule

// File: rtl/dram_init_ctrl.sv
module dram_init_ctrl
    import dinit_pkg::*;
#(
    parameter int W = REG_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    output logic [W-1:0] rd_data,
    input  logic         refresh_active,
    input  logic         access_busy,
    input  logic         init_done,
    input  logic         cmd_done,
    output logic         cmd_issue,
    output logic         cke,
    output logic         hold_traffic
);
    logic init_mode, cke_ctl, cmd_ready;

    dinit_mode_fsm u_mode (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en),
        .wr_mode(wr_data[B_MODE]), .wr_cke(wr_data[B_CKE]),
        .access_busy(access_busy), .init_done(init_done),
        .init_mode(init_mode), .cke_ctl(cke_ctl)
    );

    dinit_cmd_fsm u_cmd (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en),
        .wr_cmd(wr_data[B_CMD]), .init_mode(init_mode),
        .cmd_done(cmd_done), .cmd_issue(cmd_issue), .cmd_ready(cmd_ready)
    );

    dinit_readback #(.W(W)) u_rb (
        .init_mode(init_mode), .cke_ctl(cke_ctl),
        .refresh_active(refresh_active), .access_busy(access_busy),
        .cmd_ready(cmd_ready), .rd_data(rd_data)
    );

    always_comb begin
        cke          = init_mode ? cke_ctl : 1'b1;
        hold_traffic = init_mode;
    end
endmodule

// File: rtl/dinit_checker.sv
module dinit_checker #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic         wr_en,
    input logic [W-1:0] wr_data,
    input logic [W-1:0] rd_data,
    input logic         access_busy,
    input logic         init_done,
    input logic         cmd_issue,
    input logic         cke
);
    p_issue_one_cycle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_issue |=> !cmd_issue);

    p_ready_low_on_issue_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_issue |-> !rd_data[1]);

    p_issue_needs_ready_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cmd_issue) |-> $past(wr_en && wr_data[0] && rd_data[1]));

    p_cke_high_normal_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_data[15] |-> cke);

    p_done_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |=> !rd_data[15]);

    p_entry_refused_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_data[15] && wr_en && wr_data[15] && access_busy) |=> !rd_data[15]);

    p_no_ready_normal_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_data[15] |-> !rd_data[1]);

    p_reserved_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data[13:4] == '0) && !rd_data[0]);
endmodule

bind dram_init_ctrl dinit_checker #(.W(W)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .access_busy(access_busy), .init_done(init_done),
    .cmd_issue(cmd_issue), .cke(cke)
);

// File: tb/dram_init_ctrl_tb_top.sv
module dram_init_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [15:0] wr_data = '0;
    logic [15:0] rd_data;
    logic        refresh_active = 1'b0;
    logic        access_busy = 1'b0;
    logic        init_done = 1'b0;
    logic        cmd_done = 1'b0;
    logic        cmd_issue, cke, hold_traffic;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    dram_init_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .refresh_active(refresh_active),
        .access_busy(access_busy), .init_done(init_done),
        .cmd_done(cmd_done), .cmd_issue(cmd_issue), .cke(cke),
        .hold_traffic(hold_traffic)
    );

    typedef struct packed {
        logic        wr;
        logic [15:0] data;
        logic        busy;
        logic        idone;
        logic        cdone;
        logic [15:0] exp_rd;
        logic        exp_cke;
        logic        exp_iss;
    } vec_t;

    localparam int NV = 19;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 16'h0000, 1'b0, 1'b0, 1'b0, 16'h8002, 1'b0, 1'b0}, // R1 idle after reset
        '{1'b1, 16'hC000, 1'b0, 1'b0, 1'b0, 16'hC002, 1'b1, 1'b0}, // R4 cke follows bit 14
        '{1'b1, 16'hFFF1, 1'b0, 1'b0, 1'b0, 16'hC000, 1'b1, 1'b1}, // R6 R9 accept
        '{1'b0, 16'h0000, 1'b0, 1'b0, 1'b0, 16'hC000, 1'b1, 1'b0}, // R9 single pulse, waiting
        '{1'b1, 16'hC001, 1'b0, 1'b0, 1'b0, 16'hC000, 1'b1, 1'b0}, // R10 not ready
        '{1'b0, 16'h0000, 1'b0, 1'b0, 1'b1, 16'hC002, 1'b1, 1'b0}, // R9 done restores ready
        '{1'b1, 16'h8000, 1'b0, 1'b0, 1'b0, 16'h8002, 1'b0, 1'b0}, // R4 cke low
        '{1'b0, 16'h0000, 1'b0, 1'b1, 1'b0, 16'h0000, 1'b1, 1'b0}, // R2 hardware clear
        '{1'b1, 16'h4001, 1'b0, 1'b0, 1'b0, 16'h0000, 1'b1, 1'b0}, // R5 R10 ignored in normal
        '{1'b1, 16'h8000, 1'b1, 1'b0, 1'b0, 16'h0000, 1'b1, 1'b0}, // R3 entry refused when busy
        '{1'b1, 16'h8000, 1'b0, 1'b0, 1'b0, 16'h8002, 1'b0, 1'b0}, // R3 R5 entry, cke still 0
        '{1'b1, 16'h8000, 1'b0, 1'b1, 1'b0, 16'h0000, 1'b1, 1'b0}, // R2 done beats write
        '{1'b1, 16'h8000, 1'b0, 1'b0, 1'b0, 16'h8002, 1'b0, 1'b0}, // R3 re-enter
        '{1'b1, 16'h4001, 1'b0, 1'b0, 1'b0, 16'h4000, 1'b1, 1'b1}, // R3 R9 exit plus command
        '{1'b0, 16'h0000, 1'b0, 1'b0, 1'b0, 16'h4000, 1'b1, 1'b0}, // R8 no ready in normal
        '{1'b0, 16'h0000, 1'b0, 1'b0, 1'b1, 16'h4000, 1'b1, 1'b0}, // R8 done in normal
        '{1'b1, 16'h8000, 1'b0, 1'b0, 1'b0, 16'hC002, 1'b1, 1'b0}, // R4 stored bit 14 now 1
        '{1'b1, 16'hC001, 1'b0, 1'b0, 1'b0, 16'hC000, 1'b1, 1'b1}, // R9 accept again
        '{1'b0, 16'h0000, 1'b0, 1'b0, 1'b1, 16'hC002, 1'b1, 1'b0}  // R9 done during issue
    };

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic step(input vec_t v);
        wr_en = v.wr; wr_data = v.data; access_busy = v.busy;
        init_done = v.idone; cmd_done = v.cdone;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0; access_busy = 1'b0;
        init_done = 1'b0; cmd_done = 1'b0;
        #1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R1 reset rd_data", rd_data, 16'h8002);
        check("R1 reset cke", {15'd0, cke}, 16'd0);
        check("R1 reset cmd_issue", {15'd0, cmd_issue}, 16'd0);

        for (int i = 0; i < NV; i++) begin
            step(VECS[i]);
            check($sformatf("vector %0d rd_data", i), rd_data, VECS[i].exp_rd);
            check($sformatf("vector %0d cke", i), {15'd0, cke}, {15'd0, VECS[i].exp_cke});
            check($sformatf("vector %0d cmd_issue", i), {15'd0, cmd_issue}, {15'd0, VECS[i].exp_iss});
            check($sformatf("vector %0d R11 hold_traffic", i), {15'd0, hold_traffic},
                  {15'd0, VECS[i].exp_rd[15]});
        end

        // R7 status inputs appear in the same cycle
        refresh_active = 1'b1; access_busy = 1'b1; #1;
        check("R7 status both", rd_data, 16'hC00E);
        refresh_active = 1'b0; #1;
        check("R7 busy only", rd_data, 16'hC006);
        access_busy = 1'b0; refresh_active = 1'b1; #1;
        check("R7 refresh only", rd_data, 16'hC00A);
        refresh_active = 1'b0;

        // R1 reset from a non-reset state (normal mode, cke stored 1)
        @(negedge clk); wr_en = 1'b1; wr_data = 16'h4000;
        @(negedge clk); wr_en = 1'b0; wr_data = '0; #1;
        check("R3 exit by write", rd_data, 16'h4000);
        rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1; #1;
        check("R1 second reset rd_data", rd_data, 16'h8002);
        check("R1 second reset cke", {15'd0, cke}, 16'd0);

        finished = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule